// File: doc/BRIEF.md
# Translation Lookaside Cache with Global Entries

This block is a small fully associative cache of address translations. Each entry maps a virtual page number onto a physical frame number and carries permission and status flags. A processor core presents a virtual page number on the lookup port. Hit, frame number and protection fault come back in the same cycle. Only a miss sends the core to a table walker. The walker then installs the translation through the fill port.

There are two ways to invalidate entries. A root-table switch discards every entry except those marked global. Shared supervisor mappings are installed with the global flag set and the user flag clear, so they stay resident across address-space changes. Writing the same root base again is the way to request a plain flush of non-global entries. A single-page invalidate removes only the entry that translates the given page.

The accessed and dirty flags are sticky. When a successful lookup finds either flag clear, the block sets it. On the following cycle it also emits an update request, so that the in-memory table entry can be marked as well. Huge entries cover 2 MiB and compare only the upper page-number bits. Their frame number takes its low bits from the looked-up page number.

Top module: `vxlat_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid: any lookup misses and no update request is raised.
- R2: A lookup of a page that was filled asserts hit in the same cycle with the stored frame number. A page number that differs in any compared bit misses. At most one entry matches a lookup.
- R3: An entry filled with the huge flag matches any page number whose bits [35:9] equal its own. Its output frame number is the stored frame with bits [8:0] replaced by bits [8:0] of the looked-up page number.
- R4: A pulse on root_wr removes every entry whose global flag is clear and keeps every global entry. Repeating the pulse with no other change flushes the non-global entries again.
- R5: A single-page invalidate removes only the entry matching inv_vpn (under the same huge-aware compare). It leaves all other entries intact. Invalidating an absent page changes nothing.
- R6: lk_fault is asserted, together with hit, for a write lookup to an entry whose writable flag is clear. It is also asserted for a user-mode lookup to an entry whose user flag is clear. A supervisor read of such an entry hits without a fault.
- R7: A non-faulting hit on an entry whose accessed flag is clear sets that flag. On the next cycle upd_valid is high with upd_vpn equal to the looked-up page and upd_accessed high. Later hits on the entry raise no request.
- R8: A non-faulting write hit on an entry whose dirty flag is clear sets it and raises an update request with upd_dirty high. Later writes raise none. A faulting lookup changes no flag and raises no request.
- R9: A fill goes to the lowest-numbered invalid entry. When every entry is valid it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances only on such replacements.
- R10: A fill and an invalidate in the same cycle apply the invalidate first. An entry freed by the invalidate is available to the fill. A fill of the page being invalidated leaves the new translation resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a write access |
| lk_user | input | 1 | Lookup is from user mode |
| lk_hit | output | 1 | Translation found (same cycle) |
| lk_pfn | output | 34 | Translated frame number |
| lk_fault | output | 1 | Permission violation on the hit entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 36 | Page number of the new entry |
| fill_pfn | input | 34 | Frame number of the new entry |
| fill_writable | input | 1 | Writes permitted |
| fill_user | input | 1 | User-mode access permitted |
| fill_global | input | 1 | Entry survives root-table switches |
| fill_huge | input | 1 | Entry covers a 2 MiB page |
| fill_accessed | input | 1 | Initial accessed flag |
| fill_dirty | input | 1 | Initial dirty flag |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 36 | Page number to invalidate |
| root_wr | input | 1 | Root table base written: flush non-global entries |
| upd_valid | output | 1 | Request to write flags back to the table entry |
| upd_vpn | output | 36 | Page number the request refers to |
| upd_accessed | output | 1 | Accessed flag value to write back |
| upd_dirty | output | 1 | Dirty flag value to write back |

## Verification
The bench fills all sixteen entries and then checks that the replacement pointer evicts entries in order. It checks that a free slot made by an invalidate is taken before the pointer moves. A design that ignored free slots would evict a live page, and one that always advanced the pointer would evict the wrong page afterwards. Invalidate and fill are driven in the same cycle, once on different pages and once on the same page. The wrong ordering would evict an extra page, or would drop the freshly filled translation. Faulting writes are followed by a read of the same page, which catches a design that sets sticky flags or issues update requests on faulting lookups. A huge entry is probed at both edges of its 2 MiB range and just outside it.

// File: rtl/vxlat_pkg.sv
package vxlat_pkg;
  typedef struct packed {
    logic writable;
    logic user;
    logic glb;
    logic huge;
    logic accessed;
    logic dirty;
  } perm_t;
endpackage

// File: rtl/vxlat_match.sv
module vxlat_match #(
  parameter int N     = 16,
  parameter int VPN_W = 36,
  parameter int HB    = 9
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0]            ent_huge,
  input  logic [N-1:0][VPN_W-1:0] ent_tag,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            match
);
  localparam logic [VPN_W-1:0] HMASK = {{(VPN_W-HB){1'b1}}, {HB{1'b0}}};
  localparam logic [VPN_W-1:0] FMASK = {VPN_W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_valid[i] &&
      (((ent_tag[i] ^ key) & (ent_huge[i] ? HMASK : FMASK)) == '0);
  end
endmodule

// File: rtl/vxlat_victim.sv
module vxlat_victim #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  occupied,
  input  logic [IW-1:0] rr_ptr,
  output logic [IW-1:0] slot,
  output logic          use_rr
);
  always_comb begin
    slot   = rr_ptr;
    use_rr = 1'b1;
    for (int i = N-1; i >= 0; i--) begin
      if (!occupied[i]) begin
        slot   = IW'(i);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vxlat_tlb.sv
module vxlat_tlb
  import vxlat_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int HUGE_SHIFT = 21,
  parameter int PFN_W      = 34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lk_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0] lk_vpn,
  input  logic                       lk_write,
  input  logic                       lk_user,
  output logic                       lk_hit,
  output logic [PFN_W-1:0]           lk_pfn,
  output logic                       lk_fault,
  input  logic                       fill_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0] fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic                       fill_writable,
  input  logic                       fill_user,
  input  logic                       fill_global,
  input  logic                       fill_huge,
  input  logic                       fill_accessed,
  input  logic                       fill_dirty,
  input  logic                       inv_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0] inv_vpn,
  input  logic                       root_wr,
  output logic                       upd_valid,
  output logic [VA_W-PAGE_SHIFT-1:0] upd_vpn,
  output logic                       upd_accessed,
  output logic                       upd_dirty
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int HB    = HUGE_SHIFT - PAGE_SHIFT;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int FW    = $bits(perm_t);

  // Entry storage: valid bits are reset, contents are plain registers.
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  perm_t                         flg_q [ENTRIES];
  logic [IW-1:0]                 rr_q;

  logic [ENTRIES-1:0] huge_vec, glb_vec;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_fl
    assign huge_vec[i] = flg_q[i].huge;
    assign glb_vec[i]  = flg_q[i].glb;
  end

  // Lookup compare and select
  logic [ENTRIES-1:0] hit_vec;
  vxlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .HB(HB)) u_lk_match (
    .ent_valid(valid_q), .ent_huge(huge_vec), .ent_tag(tag_q),
    .key(lk_vpn), .match(hit_vec)
  );

  logic [PFN_W-1:0] sel_pfn;
  logic [FW-1:0]    sel_bits;
  perm_t            sel_flg;
  always_comb begin
    sel_pfn  = '0;
    sel_bits = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        sel_pfn  = sel_pfn | pfn_q[i];
        sel_bits = sel_bits | FW'(flg_q[i]);
      end
    end
    sel_flg = perm_t'(sel_bits);
  end

  logic need_acc, need_dirty, upd_fire;
  always_comb begin
    lk_hit     = lk_valid && (hit_vec != '0);
    lk_fault   = lk_hit && ((lk_write && !sel_flg.writable) ||
                            (lk_user && !sel_flg.user));
    lk_pfn     = sel_flg.huge ? {sel_pfn[PFN_W-1:HB], lk_vpn[HB-1:0]} : sel_pfn;
    need_acc   = !sel_flg.accessed;
    need_dirty = lk_write && !sel_flg.dirty;
    upd_fire   = lk_hit && !lk_fault && (need_acc || need_dirty);
  end

  // Invalidation: single page plus root switch, applied before a fill
  logic [ENTRIES-1:0] inv_hit, kill_vec, keep_vec;
  vxlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .HB(HB)) u_inv_match (
    .ent_valid(valid_q), .ent_huge(huge_vec), .ent_tag(tag_q),
    .key(inv_vpn), .match(inv_hit)
  );
  assign kill_vec = ({ENTRIES{inv_valid}} & inv_hit) |
                    ({ENTRIES{root_wr}} & ~glb_vec);
  assign keep_vec = valid_q & ~kill_vec;

  logic [IW-1:0] fill_slot;
  logic          fill_rr;
  vxlat_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .occupied(keep_vec), .rr_ptr(rr_q), .slot(fill_slot), .use_rr(fill_rr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= keep_vec;
      if (fill_valid) begin
        valid_q[fill_slot] <= 1'b1;
        if (fill_rr)
          rr_q <= (rr_q == IW'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (upd_fire && hit_vec[i]) begin
        flg_q[i].accessed <= 1'b1;
        if (lk_write) flg_q[i].dirty <= 1'b1;
      end
    end
    if (fill_valid && !rst) begin
      tag_q[fill_slot] <= fill_vpn;
      pfn_q[fill_slot] <= fill_pfn;
      flg_q[fill_slot] <= '{writable: fill_writable, user: fill_user,
                            glb: fill_global, huge: fill_huge,
                            accessed: fill_accessed, dirty: fill_dirty};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid    <= 1'b0;
      upd_vpn      <= '0;
      upd_accessed <= 1'b0;
      upd_dirty    <= 1'b0;
    end else begin
      upd_valid    <= upd_fire;
      upd_vpn      <= lk_vpn;
      upd_accessed <= 1'b1;
      upd_dirty    <= sel_flg.dirty || lk_write;
    end
  end
endmodule

// File: rtl/vxlat_tlb_chk.sv
module vxlat_tlb_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         lk_valid,
  input logic         lk_hit,
  input logic         lk_fault,
  input logic         fill_valid,
  input logic         root_wr,
  input logic         upd_valid,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] glb_vec
);
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) $fell(rst) |-> (valid_q == '0)); // R1
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst) lk_valid |-> $onehot0(hit_vec)); // R2
  AST_ROOT_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (rst) (root_wr && !fill_valid) |=> ((valid_q & ~glb_vec) == '0)); // R4
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst) lk_fault |-> lk_hit); // R6
  AST_UPD_FROM_CLEAN_HIT: assert property (@(posedge clk) disable iff (rst) (!lk_valid || !lk_hit || lk_fault) |=> !upd_valid); // R8
  AST_FILL_OCCUPIES: assert property (@(posedge clk) disable iff (rst) fill_valid |=> (valid_q != '0)); // R9
endmodule

bind vxlat_tlb vxlat_tlb_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_fault(lk_fault), .fill_valid(fill_valid), .root_wr(root_wr),
  .upd_valid(upd_valid), .hit_vec(hit_vec), .valid_q(valid_q),
  .glb_vec(glb_vec)
);

// File: tb/vxlat_tlb_tb_top.sv
module vxlat_tlb_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [35:0] lk_vpn = '0;
  logic        lk_hit, lk_fault;
  logic [33:0] lk_pfn;
  logic        fill_valid = 0, fill_writable = 0, fill_user = 0, fill_global = 0;
  logic        fill_huge = 0, fill_accessed = 0, fill_dirty = 0;
  logic [35:0] fill_vpn = '0;
  logic [33:0] fill_pfn = '0;
  logic        inv_valid = 0, root_wr = 0;
  logic [35:0] inv_vpn = '0;
  logic        upd_valid, upd_accessed, upd_dirty;
  logic [35:0] upd_vpn;

  int checks = 0;
  int errors = 0;

  logic        r_hit, r_fault, r_upd, r_ua, r_ud;
  logic [33:0] r_pfn;
  logic [35:0] r_uvpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  vxlat_tlb dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_writable(fill_writable), .fill_user(fill_user), .fill_global(fill_global),
    .fill_huge(fill_huge), .fill_accessed(fill_accessed), .fill_dirty(fill_dirty),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .root_wr(root_wr),
    .upd_valid(upd_valid), .upd_vpn(upd_vpn), .upd_accessed(upd_accessed),
    .upd_dirty(upd_dirty)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Lookup: outputs sampled in the lookup cycle, update request one cycle later.
  task automatic look(input logic [35:0] v, input logic w, input logic u);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_write = w; lk_user = u;
    #1;
    r_hit = lk_hit; r_pfn = lk_pfn; r_fault = lk_fault;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; lk_user = 0;
    #1;
    r_upd = upd_valid; r_uvpn = upd_vpn; r_ua = upd_accessed; r_ud = upd_dirty;
  endtask

  task automatic set_fill(input logic [35:0] v, input logic [33:0] p, input logic w,
                          input logic u, input logic g, input logic h,
                          input logic a, input logic d);
    fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_writable = w; fill_user = u;
    fill_global = g; fill_huge = h; fill_accessed = a; fill_dirty = d;
  endtask

  task automatic fill(input logic [35:0] v, input logic [33:0] p, input logic w,
                      input logic u, input logic g, input logic h,
                      input logic a, input logic d);
    @(negedge clk);
    set_fill(v, p, w, u, g, h, a, d);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic invalidate(input logic [35:0] v);
    @(negedge clk);
    inv_valid = 1; inv_vpn = v;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic root_switch();
    @(negedge clk);
    root_wr = 1;
    @(negedge clk);
    root_wr = 0;
  endtask

  task automatic expect_hit(input logic [35:0] v, input logic [33:0] p, input string req);
    look(v, 0, 0);
    check(r_hit === 1'b1, req, r_hit, 1);
    check(r_pfn === p, req, r_pfn, p);
  endtask

  task automatic expect_miss(input logic [35:0] v, input string req);
    look(v, 0, 0);
    check(r_hit === 1'b0, req, r_hit, 0);
  endtask

  task automatic t_reset();
    do_reset();
    look(36'h0, 0, 0);
    check(r_hit === 1'b0, "R1 miss after reset", r_hit, 0);
    check(r_upd === 1'b0, "R1 no update after reset", r_upd, 0);
    look(36'h517, 1, 1);
    check(r_hit === 1'b0, "R1 miss after reset", r_hit, 0);
  endtask

  task automatic t_basic();
    do_reset();
    fill(36'h0_0000_0517, 34'h0_1234_5, 1, 1, 0, 0, 1, 1);
    expect_hit(36'h0_0000_0517, 34'h0_1234_5, "R2 hit");
    expect_miss(36'h0_0000_0516, "R2 low bit differs");
    expect_miss(36'h8_0000_0517, "R2 high bit differs");
  endtask

  task automatic t_huge();
    do_reset();
    fill(36'h0_0040_0200, 34'h0_0003_A00, 1, 1, 0, 1, 1, 1);
    expect_hit(36'h0_0040_03FF, 34'h0_0003_BFF, "R3 huge top of range");
    expect_hit(36'h0_0040_0200, 34'h0_0003_A00, "R3 huge base");
    expect_miss(36'h0_0040_0400, "R3 outside huge range");
  endtask

  task automatic t_root();
    do_reset();
    fill(36'hA_0000_0001, 34'h111, 1, 0, 1, 0, 1, 1);
    fill(36'h0_0000_0002, 34'h222, 1, 1, 0, 0, 1, 1);
    root_switch();
    expect_hit(36'hA_0000_0001, 34'h111, "R4 global kept");
    expect_miss(36'h0_0000_0002, "R4 non-global flushed");
    fill(36'h0_0000_0003, 34'h333, 1, 1, 0, 0, 1, 1);
    root_switch();
    expect_miss(36'h0_0000_0003, "R4 repeat flush");
    expect_hit(36'hA_0000_0001, 34'h111, "R4 global kept on repeat");
  endtask

  task automatic t_inv();
    do_reset();
    fill(36'h10, 34'h1000, 1, 1, 0, 0, 1, 1);
    fill(36'h11, 34'h1100, 1, 1, 1, 0, 1, 1);
    fill(36'h12, 34'h1200, 1, 1, 0, 0, 1, 1);
    invalidate(36'h11);
    expect_miss(36'h11, "R5 target removed");
    expect_hit(36'h10, 34'h1000, "R5 neighbour kept");
    expect_hit(36'h12, 34'h1200, "R5 neighbour kept");
    invalidate(36'h99);
    expect_hit(36'h10, 34'h1000, "R5 absent invalidate");
    expect_hit(36'h12, 34'h1200, "R5 absent invalidate");
  endtask

  task automatic t_perm();
    do_reset();
    fill(36'h20, 34'h2000, 0, 0, 1, 0, 1, 1);
    fill(36'h21, 34'h2100, 1, 1, 0, 0, 1, 1);
    look(36'h20, 1, 0);
    check(r_hit === 1'b1 && r_fault === 1'b1, "R6 write to read-only", {r_hit, r_fault}, 2'b11);
    look(36'h20, 0, 1);
    check(r_hit === 1'b1 && r_fault === 1'b1, "R6 user to supervisor page", {r_hit, r_fault}, 2'b11);
    look(36'h20, 0, 0);
    check(r_hit === 1'b1 && r_fault === 1'b0, "R6 supervisor read ok", {r_hit, r_fault}, 2'b10);
    look(36'h21, 1, 1);
    check(r_hit === 1'b1 && r_fault === 1'b0, "R6 user write ok", {r_hit, r_fault}, 2'b10);
  endtask

  task automatic t_accdirty();
    do_reset();
    fill(36'h30, 34'h3000, 1, 1, 0, 0, 0, 0);
    fill(36'h31, 34'h3100, 0, 1, 0, 0, 0, 0);
    look(36'h30, 0, 0);
    check(r_upd === 1'b1 && r_uvpn === 36'h30, "R7 first access update", {r_upd, r_uvpn}, {1'b1, 36'h30});
    check(r_ua === 1'b1 && r_ud === 1'b0, "R7 update flags", {r_ua, r_ud}, 2'b10);
    look(36'h30, 0, 0);
    check(r_upd === 1'b0, "R7 sticky accessed", r_upd, 0);
    look(36'h30, 1, 0);
    check(r_upd === 1'b1 && r_ud === 1'b1, "R8 first write update", {r_upd, r_ud}, 2'b11);
    look(36'h30, 1, 0);
    check(r_upd === 1'b0, "R8 sticky dirty", r_upd, 0);
    look(36'h31, 1, 0);
    check(r_fault === 1'b1 && r_upd === 1'b0, "R8 fault gives no update", {r_fault, r_upd}, 2'b10);
    look(36'h31, 0, 0);
    check(r_upd === 1'b1 && r_ud === 1'b0, "R8 fault left flags clear", {r_upd, r_ud}, 2'b10);
  endtask

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 16; i++) fill(36'h100 + 36'(i), 34'h4000 + 34'(i), 1, 1, 0, 0, 1, 1);
    for (int i = 0; i < 16; i++) expect_hit(36'h100 + 36'(i), 34'h4000 + 34'(i), "R9 all resident");
    fill(36'h200, 34'h5000, 1, 1, 0, 0, 1, 1);
    expect_miss(36'h100, "R9 rr evicts entry 0");
    expect_hit(36'h101, 34'h4001, "R9 entry 1 kept");
    expect_hit(36'h200, 34'h5000, "R9 new page");
    fill(36'h201, 34'h5001, 1, 1, 0, 0, 1, 1);
    expect_miss(36'h101, "R9 rr evicts entry 1");
    invalidate(36'h105);
    fill(36'h202, 34'h5002, 1, 1, 0, 0, 1, 1);
    for (int i = 2; i < 16; i++)
      if (i != 5) expect_hit(36'h100 + 36'(i), 34'h4000 + 34'(i), "R9 free slot used first");
    expect_hit(36'h202, 34'h5002, "R9 refill of free slot");
    fill(36'h203, 34'h5003, 1, 1, 0, 0, 1, 1);
    expect_miss(36'h102, "R9 rr resumes at entry 2");
    expect_hit(36'h103, 34'h4003, "R9 entry 3 kept");
  endtask

  task automatic t_inv_fill();
    do_reset();
    for (int i = 0; i < 16; i++) fill(36'h100 + 36'(i), 34'h4000 + 34'(i), 1, 1, 0, 0, 1, 1);
    @(negedge clk);
    inv_valid = 1; inv_vpn = 36'h107;
    set_fill(36'h300, 34'h6000, 1, 1, 0, 0, 1, 1);
    @(negedge clk);
    inv_valid = 0; fill_valid = 0;
    expect_hit(36'h300, 34'h6000, "R10 fill lands");
    expect_miss(36'h107, "R10 invalidated page gone");
    expect_hit(36'h100, 34'h4000, "R10 freed slot used, no eviction");
    @(negedge clk);
    inv_valid = 1; inv_vpn = 36'h300;
    set_fill(36'h300, 34'h6ABC, 1, 1, 0, 0, 1, 1);
    @(negedge clk);
    inv_valid = 0; fill_valid = 0;
    expect_hit(36'h300, 34'h6ABC, "R10 same-page refill survives");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_huge();
    t_root();
    t_inv();
    t_perm();
    t_accdirty();
    t_replace();
    t_inv_fill();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule